// File: doc/BRIEF.md
# Power-Down Sequencer for a Small Microcontroller Core

This block runs the low-power halt of an 8-bit microcontroller core. When the core decodes its power-down instruction it raises a one-cycle strobe. The sequencer then decides whether the halt really happens. If the halt goes ahead, it clears the watchdog, updates the two status bits (power-down flag and time-out flag), stops the oscillator and freezes the core. If an enabled interrupt is already pending, the instruction passes as a no-op and nothing changes.

While the core is halted, a wake cause restarts the oscillator. A wake cause is an enabled, sleep-capable interrupt source or a watchdog time-out. The core stays frozen for a fixed start-up count and is then released. The core first executes the prefetched instruction that follows the halt. If the global interrupt enable was set and an interrupt caused the wake, a one-cycle vector request follows one instruction period later so the core branches to the interrupt address. An external reset abandons any halt and holds the core in reset.

All asynchronous wake inputs pass through two-flop synchronisers clocked by the free-running low-speed clock that also clocks the sequencer.

Top module: `pwrdn_seq`

## Requirements
- R1: After power-on reset, pd_bit = 1, to_bit = 1, osc_en = 1 and core_halt = 0, and wdt_clr, wake_pulse, vector_req and core_reset are all 0.
- R2: A sleep_stb with no pending interrupt makes the following cycle show core_halt = 1, osc_en = 0, pd_bit = 0 and to_bit = 1, with a wdt_clr pulse that lasts exactly one cycle.
- R3: A pending interrupt turns sleep_stb into a no-op. Pending means any source i with int_en[i] = 1 and a synchronised int_flag[i] = 1, whether or not it is sleep-capable. On a no-op, core_halt stays 0, pd_bit and to_bit keep their values, and wdt_clr is not pulsed.
- R4: While halted, a source wakes the core only if its enable bit, its flag and its bit in WAKE_MASK are all 1. The default WAKE_MASK is 4'b0111, so source 3 cannot wake the core. The global enable gie has no effect on wake-up.
- R5: After a wake cause, osc_en rises and core_halt falls. The fall comes 3 + STARTUP_CYCLES clock edges after the raw input changes, in the same cycle as a one-cycle wake_pulse.
- R6: vector_req pulses for one cycle, INSTR_CYCLES cycles after core_halt falls. It does so only if gie was 1 when the interrupt wake was taken; otherwise it stays 0.
- R7: A wdt_timeout pulse while halted wakes the core with the R5 timing and clears to_bit. It never produces vector_req.
- R8: A held ext_rst drives core_reset = 1 two edges later and abandons the halt: core_halt = 0 and osc_en = 1. pd_bit and to_bit are left unchanged.
- R9: A clrwdt_stb while running gives a one-cycle wdt_clr on the next cycle and sets both pd_bit and to_bit to 1.
- R10: Interrupt flags take two clock edges to reach the pending check. A flag raised one cycle too late to be seen at the strobe lets the halt complete fully and is then followed by an immediate wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-speed clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst | input | 1 | External reset request, asynchronous, active high |
| sleep_stb | input | 1 | Decoded power-down instruction strobe from the core |
| clrwdt_stb | input | 1 | Decoded watchdog-clear instruction strobe |
| int_en | input | N_SRC | Per-source interrupt enables |
| int_flag | input | N_SRC | Per-source interrupt flags, asynchronous |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out pulse, asynchronous |
| core_halt | output | 1 | Freezes the core while 1 |
| osc_en | output | 1 | Main oscillator enable |
| core_reset | output | 1 | Device reset request to the core |
| wdt_clr | output | 1 | One-cycle watchdog and postscaler clear |
| wake_pulse | output | 1 | One-cycle marker of core release after a wake |
| vector_req | output | 1 | One-cycle request to branch to the interrupt address |
| pd_bit | output | 1 | Power-down status flag |
| to_bit | output | 1 | Time-out status flag |

## Verification
The sleep strobe and the arrival of an interrupt flag can meet in the same cycle. Whether the flag is already visible past the synchroniser at that edge decides between a no-op and a complete halt followed by an immediate wake. The bench provokes both outcomes by raising the flag one or two cycles before the strobe. It judges them by the status bits, the watchdog clear and the measured wake latency. The table-driven sweep also covers sources that are enabled but not sleep-capable, flags whose enable bit is clear, watchdog wakes and recovery through external reset.

// File: rtl/pwrdn_pkg.sv
// Shared types for the power-down sequencer.
// Assumes: one clock domain for every consumer of these types.
package pwrdn_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_ASLEEP    = 2'd1,
        ST_OSC_START = 2'd2,
        ST_EXEC_NEXT = 2'd3
    } pd_state_e;
endpackage

// File: rtl/bit_sync2.sv
// Two-flop synchroniser bank, one chain per bit.
// Assumes: inputs are level or pulses at least one clock period wide.
module bit_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_chain
            logic meta_q;
            logic stab_q;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= d_async[gi];
                    stab_q <= meta_q;
                end
            end
            assign q_sync[gi] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/cycle_timer.sv
// One-shot cycle counter: expire is high in the LEN-th cycle after start.
// Assumes: LEN >= 1; abort wins over start.
module cycle_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic expire
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    // Count from zero up to LAST while running, then stop.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) run_q <= 1'b0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run_q && (cnt_q == LAST);

    // R5: the timer stops right after it expires unless restarted.
    assert_timer_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !run_q);
endmodule

// File: rtl/pwrdn_ctrl.sv
// Power-down control FSM: accepts or rejects the halt, tracks the status
// bits, selects the wake cause and sequences the release of the core.
// Assumes: flag_s, wdt_s and ext_s are already synchronised to clk.
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int               N_SRC     = 4,
    parameter logic [N_SRC-1:0] WAKE_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_stb,
    input  logic             clrwdt_stb,
    input  logic [N_SRC-1:0] int_en,
    input  logic [N_SRC-1:0] flag_s,
    input  logic             gie,
    input  logic             wdt_s,
    input  logic             ext_s,
    input  logic             start_done,
    input  logic             exec_done,
    output logic             start_go,
    output logic             exec_go,
    output logic             core_halt,
    output logic             osc_en,
    output logic             wdt_clr,
    output logic             wake_pulse,
    output logic             vector_req,
    output logic             pd_bit,
    output logic             to_bit
);
    pd_state_e state_q, state_d;
    logic pending, wake_irq, sleep_ok, leave_sleep, awake, exec_last;
    logic vec_arm_q;

    // Decode pending and wake conditions from enables and flags.
    always_comb begin
        pending     = |(int_en & flag_s);
        wake_irq    = |(int_en & flag_s & WAKE_MASK);
        awake       = (state_q == ST_RUN) || (state_q == ST_EXEC_NEXT);
        sleep_ok    = (state_q == ST_RUN) && sleep_stb && !pending && !ext_s;
        leave_sleep = (state_q == ST_ASLEEP) && (wake_irq || wdt_s) && !ext_s;
        start_go    = leave_sleep;
        exec_go     = (state_q == ST_OSC_START) && start_done && !ext_s;
        exec_last   = (state_q == ST_EXEC_NEXT) && exec_done && !ext_s;
    end

    // Next-state selection; external reset always returns to run.
    always_comb begin
        state_d = state_q;
        if (ext_s) begin
            state_d = ST_RUN;
        end else begin
            case (state_q)
                ST_RUN:       if (sleep_ok)    state_d = ST_ASLEEP;
                ST_ASLEEP:    if (leave_sleep) state_d = ST_OSC_START;
                ST_OSC_START: if (exec_go)     state_d = ST_EXEC_NEXT;
                ST_EXEC_NEXT: if (exec_last)   state_d = ST_RUN;
                default:                       state_d = ST_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Status bits: halt clears PD and sets TO, watchdog clear sets both,
    // a watchdog wake clears TO; external reset leaves them alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_bit <= 1'b1;
            to_bit <= 1'b1;
        end else if (sleep_ok) begin
            pd_bit <= 1'b0;
            to_bit <= 1'b1;
        end else if (leave_sleep && wdt_s) begin
            to_bit <= 1'b0;
        end else if (clrwdt_stb && awake && !ext_s) begin
            pd_bit <= 1'b1;
            to_bit <= 1'b1;
        end
    end

    // Registered one-cycle pulses towards watchdog and core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_clr    <= 1'b0;
            wake_pulse <= 1'b0;
            vector_req <= 1'b0;
        end else begin
            wdt_clr    <= sleep_ok || (clrwdt_stb && awake && !ext_s);
            wake_pulse <= exec_go;
            vector_req <= exec_last && vec_arm_q;
        end
    end

    // Remember at wake time whether the core must vector afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n || ext_s) vec_arm_q <= 1'b0;
        else if (leave_sleep) vec_arm_q <= wake_irq && gie;
    end

    assign core_halt = (state_q == ST_ASLEEP) || (state_q == ST_OSC_START);
    assign osc_en    = (state_q != ST_ASLEEP);

    // R2: an accepted halt freezes the core and updates the status bits.
    assert_halt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && sleep_stb && !pending && !ext_s)
        |=> (core_halt && !osc_en && !pd_bit && to_bit && wdt_clr));
    // R2: the watchdog clear never lasts two cycles.
    assert_clr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr);
    // R3: a pending interrupt makes the strobe a no-op.
    assert_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && sleep_stb && pending && !ext_s && !clrwdt_stb)
        |=> (!core_halt && !wdt_clr && pd_bit == $past(pd_bit) && to_bit == $past(to_bit)));
    // R7: a watchdog wake clears the time-out flag.
    assert_wdt_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ASLEEP) && wdt_s && !ext_s) |=> (!to_bit && osc_en));
    // R8: external reset releases the core and keeps the oscillator on.
    assert_ext_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_s |=> (!core_halt && osc_en));
    // R6: the vector request is a single pulse seen by a running core.
    assert_vec_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vector_req |-> (!core_halt && $past(!core_halt)) ##1 !vector_req);
endmodule

// File: rtl/pwrdn_seq.sv
// Top of the power-down sequencer: synchronises the asynchronous inputs,
// runs the control FSM and the two release timers.
// Assumes: clk is free-running while the main oscillator is stopped.
module pwrdn_seq #(
    parameter int               N_SRC          = 4,
    parameter logic [N_SRC-1:0] WAKE_MASK      = 4'b0111,
    parameter int               STARTUP_CYCLES = 16,
    parameter int               INSTR_CYCLES   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst,
    input  logic             sleep_stb,
    input  logic             clrwdt_stb,
    input  logic [N_SRC-1:0] int_en,
    input  logic [N_SRC-1:0] int_flag,
    input  logic             gie,
    input  logic             wdt_timeout,
    output logic             core_halt,
    output logic             osc_en,
    output logic             core_reset,
    output logic             wdt_clr,
    output logic             wake_pulse,
    output logic             vector_req,
    output logic             pd_bit,
    output logic             to_bit
);
    localparam int SW = N_SRC + 2;

    logic [SW-1:0]    sync_q;
    logic [N_SRC-1:0] flag_s;
    logic             wdt_s, ext_s;
    logic             start_go, start_done, exec_go, exec_done;

    bit_sync2 #(.WIDTH(SW)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ext_rst, wdt_timeout, int_flag}),
        .q_sync  (sync_q)
    );

    assign flag_s     = sync_q[N_SRC-1:0];
    assign wdt_s      = sync_q[N_SRC];
    assign ext_s      = sync_q[N_SRC+1];
    assign core_reset = ext_s;

    pwrdn_ctrl #(.N_SRC(N_SRC), .WAKE_MASK(WAKE_MASK)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_stb  (sleep_stb),
        .clrwdt_stb (clrwdt_stb),
        .int_en     (int_en),
        .flag_s     (flag_s),
        .gie        (gie),
        .wdt_s      (wdt_s),
        .ext_s      (ext_s),
        .start_done (start_done),
        .exec_done  (exec_done),
        .start_go   (start_go),
        .exec_go    (exec_go),
        .core_halt  (core_halt),
        .osc_en     (osc_en),
        .wdt_clr    (wdt_clr),
        .wake_pulse (wake_pulse),
        .vector_req (vector_req),
        .pd_bit     (pd_bit),
        .to_bit     (to_bit)
    );

    cycle_timer #(.LEN(STARTUP_CYCLES)) osc_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_go),
        .abort  (ext_s),
        .expire (start_done)
    );

    cycle_timer #(.LEN(INSTR_CYCLES)) exec_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (exec_go),
        .abort  (ext_s),
        .expire (exec_done)
    );

    // R4: a wake pulse only ever follows a halt that the oscillator ended.
    assert_wake_after_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(core_halt) && !core_halt && osc_en));
    // R5: a stopped oscillator always means a frozen core.
    assert_osc_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> core_halt);
endmodule

// File: tb/pwrdn_seq_tb.sv
// Self-checking bench: table sweep of halt/wake scenarios, then directed tests.
module pwrdn_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC      = 4;
    localparam int STARTUP    = 16;
    localparam int INSTR      = 4;
    localparam int WAKE_LAT   = 3 + STARTUP;
    localparam int N_VEC      = 8;

    // Fields: [15:12] en, [11:8] flag, [7] gie, [6] wdt cause, [5] flag before strobe,
    //         [4] expect no-op, [3] expect wake, [2] expect TO after, [1] expect vector
    localparam logic [15:0] VEC [N_VEC] = '{
        16'h11_3_0 << 0 | 16'h0000, // placeholder overwritten below
        16'h1100, 16'h2200, 16'h0000, 16'h1200, 16'h8800, 16'h8800, 16'h4600
    };
    localparam logic [7:0] CTL [N_VEC] = '{
        8'b0011_0110, // R3 early flag -> no-op
        8'b0000_1100, // R4 late flag, gie=0, wake, no vector
        8'b1000_1110, // R6 gie=1 -> vector
        8'b1100_1000, // R7 watchdog wake, TO cleared, no vector
        8'b0000_0000, // R4 flag not enabled -> no wake
        8'b0000_0000, // R4 source 3 not sleep-capable -> no wake
        8'b0011_0110, // R3 non-capable pending still blocks the halt
        8'b1000_1110  // R6 multiple flags, one enabled, gie=1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst = 1'b0, sleep_stb = 1'b0, clrwdt_stb = 1'b0, gie = 1'b0, wdt_timeout = 1'b0;
    logic [N_SRC-1:0] int_en = '0, int_flag = '0;
    logic core_halt, osc_en, core_reset, wdt_clr, wake_pulse, vector_req, pd_bit, to_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrdn_seq #(.N_SRC(N_SRC), .WAKE_MASK(4'b0111),
                .STARTUP_CYCLES(STARTUP), .INSTR_CYCLES(INSTR)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .sleep_stb(sleep_stb),
        .clrwdt_stb(clrwdt_stb), .int_en(int_en), .int_flag(int_flag), .gie(gie),
        .wdt_timeout(wdt_timeout), .core_halt(core_halt), .osc_en(osc_en),
        .core_reset(core_reset), .wdt_clr(wdt_clr), .wake_pulse(wake_pulse),
        .vector_req(vector_req), .pd_bit(pd_bit), .to_bit(to_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for core release; returns the number of negedges counted.
    task automatic wait_release(output int lat, input bit pulse_wdt);
        lat = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            lat++;
            if (pulse_wdt && lat == 1) wdt_timeout = 1'b0;
            if (!core_halt) break;
        end
    endtask

    initial begin
        int lat;
        nclk(3);
        rst_n = 1'b1;
        nclk(1);
        // R1 reset state
        chk("R1 pd_bit", pd_bit, 1);
        chk("R1 to_bit", to_bit, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 core_halt", core_halt, 0);
        chk("R1 pulses", {wdt_clr, wake_pulse, vector_req, core_reset}, 0);

        for (int i = 0; i < N_VEC; i++) begin
            logic [3:0] en, fl;
            logic [7:0] c;
            en = VEC[i][15:12];
            fl = VEC[i][11:8];
            if (i == 0) begin en = 4'h1; fl = 4'h1; end
            c = CTL[i];
            // R9 watchdog clear restores both status bits
            clrwdt_stb = 1'b1;
            nclk(1);
            clrwdt_stb = 1'b0;
            chk("R9 wdt_clr", wdt_clr, 1);
            chk("R9 pd/to", {pd_bit, to_bit}, 3);
            nclk(1);
            chk("R9 wdt_clr single", wdt_clr, 0);
            int_en = en;
            gie    = c[7];
            if (c[5]) int_flag = fl;
            nclk(3);
            sleep_stb = 1'b1;
            nclk(1);
            sleep_stb = 1'b0;
            if (c[4]) begin
                chk("R3 no halt", core_halt, 0);
                chk("R3 status kept", {pd_bit, to_bit}, 3);
                chk("R3 no wdt_clr", wdt_clr, 0);
            end else begin
                chk("R2 halt/osc", {core_halt, osc_en}, 2);
                chk("R2 pd/to", {pd_bit, to_bit}, 1);
                chk("R2 wdt_clr", wdt_clr, 1);
                nclk(1);
                chk("R2 wdt_clr one cycle", wdt_clr, 0);
                if (c[6]) wdt_timeout = 1'b1;
                else      int_flag = fl;
                if (c[3]) begin
                    wait_release(lat, c[6]);
                    chk(c[6] ? "R7 wake latency" : "R5 wake latency", lat, WAKE_LAT);
                    chk("R5 wake_pulse", wake_pulse, 1);
                    chk(c[6] ? "R7 to_bit" : "R4 to_bit", to_bit, c[2]);
                    nclk(INSTR - 1);
                    chk("R6 no early vector", vector_req, 0);
                    nclk(1);
                    chk("R6 vector_req", vector_req, c[1]);
                    nclk(1);
                    chk("R6 vector single", vector_req, 0);
                end else begin
                    nclk(40);
                    chk("R4 still halted", core_halt, 1);
                    chk("R4 osc off", osc_en, 0);
                    ext_rst = 1'b1;
                    nclk(4);
                    chk("R8 core_reset", core_reset, 1);
                    chk("R8 released", {core_halt, osc_en}, 1);
                    chk("R8 status kept", {pd_bit, to_bit}, 1);
                    ext_rst = 1'b0;
                    nclk(4);
                    chk("R8 reset released", core_reset, 0);
                end
            end
            int_flag = '0;
            int_en   = '0;
            nclk(4);
        end

        // R10 flag one cycle too late for the pending check: halt then wake
        int_en = 4'h1;
        gie    = 1'b0;
        int_flag = 4'h1;
        nclk(1);
        sleep_stb = 1'b1;
        nclk(1);
        sleep_stb = 1'b0;
        chk("R10 halt completed", {core_halt, pd_bit, wdt_clr}, 5);
        wait_release(lat, 1'b0);
        chk("R10 immediate wake", lat, STARTUP + 1);
        int_flag = '0;
        nclk(INSTR + 4);
        clrwdt_stb = 1'b1;
        nclk(1);
        clrwdt_stb = 1'b0;
        nclk(1);
        // R10 flag visible at the strobe edge: no-op
        int_flag = 4'h1;
        nclk(2);
        sleep_stb = 1'b1;
        nclk(1);
        sleep_stb = 1'b0;
        chk("R10 no-op", {core_halt, pd_bit, wdt_clr}, 2);
        int_flag = '0;
        int_en   = '0;
        nclk(3);

        // R4 gie has no effect on wake: gie=1 with watchdog not involved, source 0
        int_en = 4'h1;
        gie    = 1'b1;
        sleep_stb = 1'b1;
        nclk(1);
        sleep_stb = 1'b0;
        int_flag = 4'h1;
        wait_release(lat, 1'b0);
        chk("R4 wake with gie=1", lat, WAKE_LAT);
        int_flag = '0;
        nclk(INSTR + 3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule